// File: doc/BRIEF.md
# Frame-Clock Resynchronizing Timing Generator

This block derives all per-sample internal timing from the free-running system clock. It does not take that timing from the incoming frame clock, so jitter on the frame clock never reaches downstream timing. A phase counter steps once per system clock and wraps after 384 or 256 clocks, as `len_sel_i` selects. The counter starts on the first start edge of the frame clock seen after reset. From then on the block compares every later start edge against its own counter. It realigns only when the edge has drifted outside a tolerance window.

Two tolerance windows are available. The narrow window accepts an edge that lands within one system clock of the expected position. The wide window accepts ±3/8 of a frame, which is ±144 clocks at 384 and ±96 clocks at 256. The frame clock is asynchronous, so it passes through a two-stage synchronizer and an edge detector before any comparison. Downstream logic uses three outputs: the frame-start pulse, the counter phase, and a one-cycle flag that marks each realignment.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is 0 and both `frame_start_o` and `resync_o` are 0.
- R2: After reset and before the first start edge, `phase_o` stays at 0 and `frame_start_o` stays 0.
- R3: Suppose a start-edge transition on `frame_clk_i` is set up before rising clock edge k. Then edge k+2 acts on it: on the first such edge after reset, `phase_o` becomes 3 and `resync_o` is 1 for that cycle.
- R4: Once aligned, `phase_o` steps by one each clock and wraps to 0 after 383 (`len_sel_i`=1) or after 255 (`len_sel_i`=0). `frame_start_o` is 1 exactly in the cycles where `phase_o` is 0.
- R5: The start edge is the falling edge when `fmt_a_i`=1 and `fmt_b_i`=0, and the rising edge for the other three combinations. The opposite transition is ignored.
- R6: The edge error is the counter phase during detection minus 2, wrapped into [-L/2, L/2). With `wide_tol_i`=0 the counter realigns (loads 3) only when the magnitude of this error exceeds 1. Otherwise it keeps counting undisturbed.
- R7: With `wide_tol_i`=1 the counter realigns only when the error magnitude exceeds 144 (`len_sel_i`=1) or 96 (`len_sel_i`=0).
- R8: `resync_o` is a single-cycle pulse, raised in exactly the cycle in which the realigned phase 3 first appears on `phase_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| frame_clk_i | input | 1 | asynchronous input frame clock |
| len_sel_i | input | 1 | 1: 384-clock frame, 0: 256-clock frame |
| wide_tol_i | input | 1 | 1: ±3/8-frame window, 0: ±1-clock window |
| fmt_a_i | input | 1 | format select A (start-edge polarity) |
| fmt_b_i | input | 1 | format select B (start-edge polarity) |
| frame_start_o | output | 1 | high while phase is 0 after alignment |
| phase_o | output | 9 | frame phase counter |
| resync_o | output | 1 | one-cycle realignment flag |

## Verification
The bench drives the frame clock with directed offset sequences, and with seeded random per-frame offsets, in both frame lengths and both tolerance modes.

- Offsets of ±1 against ±2 separate the narrow window's accept and reject sides.
- Offsets of 144 against 145, and of 96 against 97, do the same for the wide window's boundary.
- A return to the original grid after a realignment proves that the counter adopted the new grid.
- A falling-edge format run with rising transitions in between shows that only the selected polarity is acted on.
- Wrap spacing is measured between frame-start pulses.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  function automatic edge_pol_e start_pol(input logic fmt_a, input logic fmt_b);
    return (fmt_a && !fmt_b) ? EDGE_FALL : EDGE_RISE;
  endfunction
endpackage

// File: rtl/fsg_edge_det.sv
module fsg_edge_det
  import fsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      async_i,
  input  edge_pol_e pol_i,
  output logic      edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [SYNC_STAGES:0]   vld_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  // vld_q masks the chain until it holds real samples after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      vld_q  <= '0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      vld_q  <= {vld_q[SYNC_STAGES-1:0], 1'b1};
    end
  end

  logic lvl, rise, fall;
  always_comb begin
    lvl    = sync_q[SYNC_STAGES-1];
    rise   = lvl & ~prev_q;
    fall   = ~lvl & prev_q;
    edge_o = vld_q[SYNC_STAGES] & ((pol_i == EDGE_FALL) ? fall : rise);
  end
endmodule

// File: rtl/fsg_err_chk.sv
module fsg_err_chk #(
  parameter int LEN_HI  = 384,
  parameter int LEN_LO  = 256,
  parameter int TOL_NUM = 3,
  parameter int TOL_DEN = 8,
  parameter int ZERO_PH = 2,
  parameter int PW      = 9
) (
  input  logic [PW-1:0] phase_i,
  input  logic          len_sel_i,
  input  logic          wide_i,
  output logic          viol_o
);
  localparam int EW         = PW + 2;
  localparam int TOL_HI     = LEN_HI * TOL_NUM / TOL_DEN;
  localparam int TOL_LO     = LEN_LO * TOL_NUM / TOL_DEN;
  localparam int NARROW_TOL = 1;

  logic signed [EW-1:0] flen, err_raw, err_wrap, err_mag, tol;

  always_comb begin
    flen     = len_sel_i ? EW'(LEN_HI) : EW'(LEN_LO);
    err_raw  = $signed({2'b00, phase_i}) - $signed(EW'(ZERO_PH));
    // fold into [-L/2, L/2)
    err_wrap = (err_raw >= (flen >>> 1)) ? err_raw - flen : err_raw;
    err_mag  = err_wrap[EW-1] ? -err_wrap : err_wrap;
    tol      = wide_i ? (len_sel_i ? EW'(TOL_HI) : EW'(TOL_LO)) : EW'(NARROW_TOL);
    viol_o   = err_mag > tol;
  end
endmodule

// File: rtl/fsg_phase_ctr.sv
module fsg_phase_ctr #(
  parameter int LEN_HI  = 384,
  parameter int LEN_LO  = 256,
  parameter int PW      = 9,
  parameter int LOAD_PH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          len_sel_i,
  input  logic          edge_i,
  input  logic          viol_i,
  output logic [PW-1:0] phase_o,
  output logic          run_o,
  output logic          resync_o
);
  logic [PW-1:0] ph_q, last_ph;
  logic          run_q, rs_q, realign;

  always_comb begin
    last_ph = len_sel_i ? PW'(LEN_HI - 1) : PW'(LEN_LO - 1);
    realign = edge_i & (~run_q | viol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      run_q <= 1'b0;
      rs_q  <= 1'b0;
    end else begin
      rs_q <= realign;
      if (realign) begin
        ph_q  <= PW'(LOAD_PH);
        run_q <= 1'b1;
      end else if (run_q) begin
        ph_q <= (ph_q >= last_ph) ? '0 : ph_q + 1'b1;
      end
    end
  end

  assign phase_o  = ph_q;
  assign run_o    = run_q;
  assign resync_o = rs_q;
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
#(
  parameter int LEN_HI      = 384,
  parameter int LEN_LO      = 256,
  parameter int TOL_NUM     = 3,
  parameter int TOL_DEN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_clk_i,
  input  logic                      len_sel_i,
  input  logic                      wide_tol_i,
  input  logic                      fmt_a_i,
  input  logic                      fmt_b_i,
  output logic                      frame_start_o,
  output logic [$clog2(LEN_HI)-1:0] phase_o,
  output logic                      resync_o
);
  localparam int PW      = $clog2(LEN_HI);
  localparam int ZERO_PH = SYNC_STAGES;
  localparam int LOAD_PH = ZERO_PH + 1;

  edge_pol_e     pol;
  logic          edge_w, viol_w, run_w;
  logic [PW-1:0] ph_w;

  assign pol = start_pol(fmt_a_i, fmt_b_i);

  fsg_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(frame_clk_i),
    .pol_i  (pol),
    .edge_o (edge_w)
  );

  fsg_err_chk #(
    .LEN_HI(LEN_HI), .LEN_LO(LEN_LO), .TOL_NUM(TOL_NUM),
    .TOL_DEN(TOL_DEN), .ZERO_PH(ZERO_PH), .PW(PW)
  ) u_err (
    .phase_i  (ph_w),
    .len_sel_i(len_sel_i),
    .wide_i   (wide_tol_i),
    .viol_o   (viol_w)
  );

  fsg_phase_ctr #(
    .LEN_HI(LEN_HI), .LEN_LO(LEN_LO), .PW(PW), .LOAD_PH(LOAD_PH)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_sel_i(len_sel_i),
    .edge_i   (edge_w),
    .viol_i   (viol_w),
    .phase_o  (ph_w),
    .run_o    (run_w),
    .resync_o (resync_o)
  );

  assign phase_o       = ph_w;
  assign frame_start_o = run_w & (ph_w == '0);
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
  parameter int LEN_HI  = 384,
  parameter int PW      = 9,
  parameter int LOAD_PH = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wide_tol_i,
  input logic          frame_start_o,
  input logic [PW-1:0] phase_o,
  input logic          resync_o,
  input logic          edge_i,
  input logic          run_i
);
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (phase_o == '0) && !frame_start_o);

  // R3
  first_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !run_i) |=> resync_o && run_i);

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !resync_o && $past(run_i)) |->
      (phase_o == $past(phase_o) + 1'b1) || (phase_o == '0));

  // R4
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PW'(LEN_HI));

  // R6
  narrow_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && run_i && !wide_tol_i && phase_o >= 1 && phase_o <= 3) |=> !resync_o);

  // R6
  narrow_slip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && run_i && !wide_tol_i && (phase_o < 1 || phase_o > 3)) |=> resync_o);

  // R8
  load_ph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> phase_o == PW'(LOAD_PH));

  // R8
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o);
endmodule

bind frame_sync_gen fsg_chk #(.LEN_HI(LEN_HI), .PW(PW), .LOAD_PH(LOAD_PH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wide_tol_i   (wide_tol_i),
  .frame_start_o(frame_start_o),
  .phase_o      (phase_o),
  .resync_o     (resync_o),
  .edge_i       (edge_w),
  .run_i        (run_w)
);

// File: tb/frame_sync_gen_tb.sv
module frame_sync_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fr = 1'b0;
  logic       len_sel = 1'b1, wide = 1'b0, fa = 1'b0, fb = 1'b0;
  logic       fs_o, rs_o;
  logic [8:0] ph_o;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R4";
  bit    chk_en = 1'b0;
  int    rs_seen = 0;

  // model state
  bit ev = 0, d0 = 0, d1 = 0, m_run = 0, m_rs = 0;
  int m_ph = 0;

  always #2.5 clk = ~clk;

  frame_sync_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_clk_i(fr), .len_sel_i(len_sel),
    .wide_tol_i(wide), .fmt_a_i(fa), .fmt_b_i(fb),
    .frame_start_o(fs_o), .phase_o(ph_o), .resync_o(rs_o)
  );

  function automatic int flen();
    return len_sel ? 384 : 256;
  endfunction

  function automatic bit viol(int ph);
    int e, tol;
    e = ph - 2;
    if (e >= flen() / 2) e -= flen();
    if (e < 0) e = -e;
    tol = wide ? flen() * 3 / 8 : 1;
    return e > tol;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    bit det;
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_rs = 0; d0 = 0; d1 = 0;
    end else begin
      det = d1; d1 = d0; d0 = ev; ev = 0;
      m_rs = 0;
      if (!m_run) begin
        if (det) begin m_run = 1; m_ph = 3; m_rs = 1; end
      end else if (det && viol(m_ph)) begin
        m_ph = 3; m_rs = 1;
      end else begin
        m_ph = (m_ph >= flen() - 1) ? 0 : m_ph + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      check(cur_req, "phase_o", int'(ph_o), m_ph);
      check(cur_req, "resync_o", int'(rs_o), int'(m_rs));
      check(cur_req, "frame_start_o", int'(fs_o), int'(m_run && m_ph == 0));
      if (rs_o) rs_seen++;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit ls, bit wd, bit a, bit b);
    chk_en = 0;
    @(negedge clk);
    rst_n = 0;
    len_sel = ls; wide = wd; fa = a; fb = b;
    fr = (a && !b) ? 1'b1 : 1'b0;
    wait_cyc(4);
    // R1
    check("R1", "phase_o in reset", int'(ph_o), 0);
    check("R1", "frame_start_o in reset", int'(fs_o), 0);
    check("R1", "resync_o in reset", int'(rs_o), 0);
    rst_n = 1;
    chk_en = 1;
    wait_cyc(12);
    // R2
    check("R2", "phase_o before edge", int'(ph_o), 0);
    check("R2", "frame_start_o before edge", int'(fs_o), 0);
    rs_seen = 0;
  endtask

  // offsets relative to the grid set by frame 0; rnd picks them in [-mj, mj]
  task automatic frames(int n, int offs[8], bit rnd, int mj, bit first_chk);
    int  cur, tgt, off, h, len;
    bit  st;
    len = flen();
    h   = len / 4;
    st  = (fa && !fb) ? 1'b0 : 1'b1;
    cur = 0;
    for (int k = 0; k < n; k++) begin
      off = rnd ? (k == 0 ? 0 : int'($urandom_range(2 * mj)) - mj) : offs[k];
      tgt = (k + 1) * len + off;
      wait_cyc(tgt - cur);
      fr = st; ev = 1;
      cur = tgt;
      if (first_chk && k == 0) begin
        wait_cyc(3);
        // R3
        check("R3", "phase after first edge", int'(ph_o), 3);
        check("R3", "resync after first edge", int'(rs_o), 1);
        wait_cyc(1);
        // R8
        check("R8", "resync width", int'(rs_o), 0);
        check("R8", "phase after load", int'(ph_o), 4);
        wait_cyc(h - 4);
      end else begin
        wait_cyc(h);
      end
      fr = ~st;
      cur += h;
    end
    wait_cyc(len);
  endtask

  task automatic measure_len(string req, int exp);
    int c = 0;
    for (int i = 0; i < 1000 && !fs_o; i++) @(negedge clk);
    @(negedge clk);
    while (!fs_o && c < 1000) begin c++; @(negedge clk); end
    check(req, "frame_start spacing", c + 1, exp);
  endtask

  int z[8] = '{0, 0, 0, 0, 0, 0, 0, 0};

  initial begin
    void'($urandom(32'd5843));
    wait_cyc(2);

    // R3 R4: clean 384 grid, narrow
    do_reset(1, 0, 0, 0);
    cur_req = "R4";
    frames(6, z, 0, 0, 1);
    check("R4", "no realign on clean grid", rs_seen, 1);
    measure_len("R4", 384);

    // R6: narrow window boundary
    do_reset(1, 0, 0, 0);
    cur_req = "R6";
    frames(7, '{0, 0, 1, -1, 0, 2, 0, 0}, 0, 0, 0);
    check("R6", "narrow realign count", rs_seen, 3);

    // R7: wide window boundary at 384
    do_reset(1, 1, 0, 1);
    cur_req = "R7";
    frames(6, '{0, 0, 144, 0, 145, 0, 0, 0}, 0, 0, 0);
    check("R7", "wide 384 realign count", rs_seen, 3);

    // R7: wide window boundary at 256, plus R4 wrap
    do_reset(0, 1, 1, 1);
    cur_req = "R7";
    frames(5, '{0, 96, 0, 97, 0, 0, 0, 0}, 0, 0, 0);
    check("R7", "wide 256 realign count", rs_seen, 3);
    measure_len("R4", 256);

    // R5: falling start edge; rising transitions must not realign
    do_reset(1, 0, 1, 0);
    cur_req = "R5";
    frames(5, z, 0, 0, 1);
    check("R5", "falling-edge realign count", rs_seen, 1);

    // R6 random small jitter
    do_reset(1, 0, 0, 0);
    cur_req = "R6";
    frames(30, z, 1, 3, 0);

    // R7 random wide jitter, both lengths
    do_reset(1, 1, 0, 0);
    cur_req = "R7";
    frames(30, z, 1, 140, 0);
    do_reset(0, 1, 0, 0);
    cur_req = "R7";
    frames(30, z, 1, 90, 0);

    chk_en = 0;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout, all requirements, got hang exp finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule